// File: doc/BRIEF.md
# IR Run-Length Codec

This block sits between a bit-level IR serial channel and a byte-wide data path. On the transmit side it gathers a stream of single bits, offered as a valid/bit pair, into compact code words. Each code word describes one run of identical bits. The code words leave through a valid/ready handshake. On the receive side it takes code words through a valid/ready handshake and plays the bits back, one bit per pulse of a bit-time strobe.

Each code word holds the run's bit value in its most significant bit and the run length minus one in the `CNT_W` bits below it. With the default `CNT_W = 7` the word is one byte, and a single word covers 1 to 128 equal bits. A longer run is split across several words that carry the same value.

An enable input chooses between run-length coding and plain bypass. In bypass, the encoder packs every `CNT_W+1` bits into one data word, LSB first. The decoder then shifts each word out LSB first. The enable input is captured into a mode register. That register only follows the input while both directions are idle, so a mode change never splits a run or a word.

Top module: `ir_rle_codec`

## Requirements
- R1: After reset, `enc_valid` and `rx_bit_valid` are 0, `tx_bit_ready` and `dec_ready` are 1, and the mode register holds bypass, whatever the level of `rle_en`.
- R2: A code word is `{value, length-1}`. Bit `CNT_W` holds the run's bit value and bits `CNT_W-1:0` hold the length minus one. The length ranges from 1 to 2^CNT_W.
- R3: In coding mode, when a bit that differs from the pending run is accepted, the word for the pending run is valid on the next cycle. The new bit starts a fresh run.
- R4: In coding mode, the bit that brings a run to 2^CNT_W bits causes that run's word (count field all ones) to be valid on the next cycle. Further bits of the same value start a new run.
- R5: A flush pulse emits any pending run, or in bypass any partly filled word with its unfilled high bits at 0, on the next cycle. With nothing pending, a flush emits nothing. No bit is accepted during a flush cycle.
- R6: While an encoded word is valid and `enc_ready` is low, the word is held stable and `tx_bit_ready` stays low.
- R7: In coding mode, the decoder drives the word's top bit on `rx_bit` for exactly length (count field + 1) strobes. It marks each of those strobes with `rx_bit_valid`.
- R8: `dec_ready` is low from the cycle after a word is accepted until its last bit has been strobed out. A second word is taken only after that, and its bits follow the first word's bits.
- R9: In bypass, the encoder places the k-th accepted bit at bit k of the data word. The word is valid the cycle after the `CNT_W+1`-th bit.
- R10: In bypass, the decoder emits a word's bits from bit 0 upward, one per strobe, `CNT_W+1` bits in all.
- R11: A change of `rle_en` reaches the mode register only in a cycle when both paths are idle and neither `tx_bit_valid`, `tx_flush` nor `dec_valid` is high. Until then, a pending run keeps being coded in the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rle_en | input | 1 | 1 selects run-length coding, 0 selects bypass |
| tx_bit_valid | input | 1 | A transmit bit is offered |
| tx_bit | input | 1 | Transmit bit value |
| tx_flush | input | 1 | Pulse: close the pending run or partial word |
| tx_bit_ready | output | 1 | Transmit bit accepted this cycle when valid |
| enc_word | output | CNT_W+1 | Encoded word (or raw word in bypass) |
| enc_valid | output | 1 | `enc_word` is valid |
| enc_ready | input | 1 | Downstream takes `enc_word` |
| dec_word | input | CNT_W+1 | Word to decode (or raw word in bypass) |
| dec_valid | input | 1 | `dec_word` is valid |
| dec_ready | output | 1 | Decoder takes `dec_word` |
| bit_strobe | input | 1 | Bit-time strobe for replay |
| rx_bit | output | 1 | Replayed bit value |
| rx_bit_valid | output | 1 | `rx_bit` is delivered in this strobe cycle |

## Verification
The bench builds the codec with `CNT_W = 3`. This gives 4-bit words and a longest run of 8 bits, so a run that fills the count field and a run that spills into a second word of the same value each take only a handful of bits. The same setting shrinks bypass words to four bits. The partial-word flush, the LSB-first packing and the LSB-first replay are therefore covered with short sequences. The replay strobe fires every third cycle, so the hold of `rx_bit` and `dec_ready` between strobes is also covered.

// File: rtl/ir_rle_pkg.sv
// Shared types for the IR run-length codec.
// Assumes: nothing beyond IEEE 1800-2017.
package ir_rle_pkg;

    typedef enum logic {
        MODE_RAW = 1'b0,
        MODE_RLE = 1'b1
    } codec_mode_e;

endpackage

// File: rtl/ir_rle_enc.sv
// Encoder: turns accepted bits into run-length code words (coding mode)
// or into LSB-first data words (bypass), one word held in an output register.
// Assumes: mode only changes while idle is high and no bit or flush is offered;
// flush acts only in a cycle with no word waiting.
module ir_rle_enc
    import ir_rle_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  codec_mode_e      mode,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             flush,
    output logic             in_ready,
    output logic [CNT_W:0]   out_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             idle
);
    localparam int W  = CNT_W + 1;
    localparam int NW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((1 << CNT_W) - 2);
    localparam logic [NW-1:0]    RAW_LAST = NW'(W - 1);

    logic             run_act, n_act;
    logic             run_val, n_val;
    logic [CNT_W-1:0] run_cnt, n_cnt;
    logic [W-1:0]     raw_sh,  n_sh;
    logic [NW-1:0]    raw_n,   n_n;
    logic [W-1:0]     out_q,   n_oq;
    logic             out_v,   n_ov;
    logic             take;

    // Bits and flush are held off while a word waits for the consumer.
    assign in_ready  = !out_v && !flush;
    assign take      = in_valid && in_ready;
    assign out_word  = out_q;
    assign out_valid = out_v;
    assign idle      = !run_act && (raw_n == '0) && !out_v;

    // Next-state logic for run tracking, raw packing and the output word.
    always_comb begin
        n_act = run_act;
        n_val = run_val;
        n_cnt = run_cnt;
        n_sh  = raw_sh;
        n_n   = raw_n;
        n_ov  = out_v;
        n_oq  = out_q;
        if (out_v && out_ready) begin
            n_ov = 1'b0;
        end
        if (mode == MODE_RLE) begin
            if (take) begin
                if (!run_act) begin
                    n_act = 1'b1;
                    n_val = in_bit;
                    n_cnt = '0;
                end else if (in_bit != run_val) begin
                    n_ov  = 1'b1;
                    n_oq  = {run_val, run_cnt};
                    n_val = in_bit;
                    n_cnt = '0;
                end else if (run_cnt == CNT_LAST) begin
                    n_ov  = 1'b1;
                    n_oq  = {run_val, CNT_MAX};
                    n_act = 1'b0;
                    n_cnt = '0;
                end else begin
                    n_cnt = run_cnt + 1'b1;
                end
            end else if (flush && !out_v && run_act) begin
                n_ov  = 1'b1;
                n_oq  = {run_val, run_cnt};
                n_act = 1'b0;
                n_cnt = '0;
            end
        end else begin
            if (take) begin
                n_sh[raw_n] = in_bit;
                if (raw_n == RAW_LAST) begin
                    n_ov = 1'b1;
                    n_oq = n_sh;
                    n_sh = '0;
                    n_n  = '0;
                end else begin
                    n_n = raw_n + 1'b1;
                end
            end else if (flush && !out_v && (raw_n != '0)) begin
                n_ov = 1'b1;
                n_oq = raw_sh;
                n_sh = '0;
                n_n  = '0;
            end
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_act <= 1'b0;
            run_val <= 1'b0;
            run_cnt <= '0;
            raw_sh  <= '0;
            raw_n   <= '0;
            out_q   <= '0;
            out_v   <= 1'b0;
        end else begin
            run_act <= n_act;
            run_val <= n_val;
            run_cnt <= n_cnt;
            raw_sh  <= n_sh;
            raw_n   <= n_n;
            out_q   <= n_oq;
            out_v   <= n_ov;
        end
    end

endmodule

// File: rtl/ir_rle_dec.sv
// Decoder: loads one word and replays it one bit per strobe. In coding mode
// the top bit is repeated count+1 times; in bypass the word shifts out LSB first.
// Assumes: mode only changes while idle is high and no word is offered.
module ir_rle_dec
    import ir_rle_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  codec_mode_e      mode,
    input  logic [CNT_W:0]   in_word,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             strobe,
    output logic             out_bit,
    output logic             out_bit_valid,
    output logic             idle
);
    localparam int W = CNT_W + 1;
    localparam logic [CNT_W-1:0] RAW_REM = CNT_W'(W - 1);

    logic             busy;
    logic             rle_q;
    logic [W-1:0]     sh;
    logic [CNT_W-1:0] rem;
    logic             load;

    assign in_ready      = !busy;
    assign load          = in_valid && !busy;
    assign idle          = !busy;
    assign out_bit       = busy && (rle_q ? sh[W-1] : sh[0]);
    assign out_bit_valid = busy && strobe;

    // Load a word, then count down remaining bits on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            rle_q <= 1'b0;
            sh    <= '0;
            rem   <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            rle_q <= (mode == MODE_RLE);
            sh    <= in_word;
            rem   <= (mode == MODE_RLE) ? in_word[CNT_W-1:0] : RAW_REM;
        end else if (busy && strobe) begin
            if (rem == '0) begin
                busy <= 1'b0;
            end else begin
                rem <= rem - 1'b1;
            end
            if (!rle_q) begin
                sh <= sh >> 1;
            end
        end
    end

endmodule

// File: rtl/ir_rle_codec.sv
// Top: IR run-length encoder and decoder sharing one mode register.
// Assumes: CNT_W >= 1; the word width is CNT_W+1.
module ir_rle_codec
    import ir_rle_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rle_en,
    input  logic             tx_bit_valid,
    input  logic             tx_bit,
    input  logic             tx_flush,
    output logic             tx_bit_ready,
    output logic [CNT_W:0]   enc_word,
    output logic             enc_valid,
    input  logic             enc_ready,
    input  logic [CNT_W:0]   dec_word,
    input  logic             dec_valid,
    output logic             dec_ready,
    input  logic             bit_strobe,
    output logic             rx_bit,
    output logic             rx_bit_valid
);
    localparam int W = CNT_W + 1;

    codec_mode_e mode_q;
    logic        enc_idle;
    logic        dec_idle;
    logic        quiet;

    assign quiet = enc_idle && dec_idle && !tx_bit_valid && !tx_flush && !dec_valid;

    // Mode register: follows rle_en only while nothing is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RAW;
        end else if (quiet) begin
            mode_q <= rle_en ? MODE_RLE : MODE_RAW;
        end
    end

    ir_rle_enc #(.CNT_W(CNT_W)) enc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .in_valid  (tx_bit_valid),
        .in_bit    (tx_bit),
        .flush     (tx_flush),
        .in_ready  (tx_bit_ready),
        .out_word  (enc_word),
        .out_valid (enc_valid),
        .out_ready (enc_ready),
        .idle      (enc_idle)
    );

    ir_rle_dec #(.CNT_W(CNT_W)) dec_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode_q),
        .in_word       (dec_word),
        .in_valid      (dec_valid),
        .in_ready      (dec_ready),
        .strobe        (bit_strobe),
        .out_bit       (rx_bit),
        .out_bit_valid (rx_bit_valid),
        .idle          (dec_idle)
    );

endmodule

// File: rtl/ir_rle_codec_chk.sv
// Checker for ir_rle_codec: handshake, stall and mode-change properties.
// Assumes: bound to every ir_rle_codec instance by the bind below.
module ir_rle_codec_chk
    import ir_rle_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_bit_valid,
    input logic         tx_bit_ready,
    input logic         tx_flush,
    input logic [W-1:0] enc_word,
    input logic         enc_valid,
    input logic         enc_ready,
    input logic         dec_valid,
    input logic         dec_ready,
    input logic         rx_bit_valid,
    input codec_mode_e  mode_q
);
    logic seen;

    // Marks cycles that have a fully reset past.
    always_ff @(posedge clk) begin
        seen <= rst_n;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!enc_valid && dec_ready && !rx_bit_valid && mode_q == MODE_RAW));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (enc_valid && !enc_ready) |=> (enc_valid && $stable(enc_word)));

    // R6
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> !tx_bit_ready);

    // R5
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> !tx_bit_ready);

    // R8
    replay_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ready) |=> !dec_ready);

    // R8
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_valid |-> !dec_ready);

    // R11
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (mode_q != $past(mode_q)) |->
        $past(!tx_bit_valid && !tx_flush && !dec_valid && dec_ready && !enc_valid));

endmodule

bind ir_rle_codec ir_rle_codec_chk #(.W(W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_bit_valid (tx_bit_valid),
    .tx_bit_ready (tx_bit_ready),
    .tx_flush     (tx_flush),
    .enc_word     (enc_word),
    .enc_valid    (enc_valid),
    .enc_ready    (enc_ready),
    .dec_valid    (dec_valid),
    .dec_ready    (dec_ready),
    .rx_bit_valid (rx_bit_valid),
    .mode_q       (mode_q)
);

// File: tb/ir_rle_codec_tb.sv
// Bench for ir_rle_codec built with CNT_W = 3 (4-bit words, runs of 1..8).
module ir_rle_codec_tb_top;
    localparam int CLK_P  = 10;
    localparam int CNT_W  = 3;
    localparam int W      = CNT_W + 1;
    localparam int WD_CYC = 20000;

    typedef struct packed {
        logic         en;
        logic [W-1:0] word;
        logic [3:0]   len;
        logic [7:0]   bits;
    } dvec_t;

    // Decoder vectors: mode, word, expected bit count, expected bits (bit i = i-th out).
    localparam dvec_t DVEC [6] = '{
        '{1'b1, 4'hA, 4'd3, 8'h07},
        '{1'b1, 4'h0, 4'd1, 8'h00},
        '{1'b1, 4'hF, 4'd8, 8'hFF},
        '{1'b1, 4'h5, 4'd6, 8'h00},
        '{1'b0, 4'hD, 4'd4, 8'h0D},
        '{1'b0, 4'h6, 4'd4, 8'h06}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rle_en = 1'b0;
    logic         tx_bit_valid = 1'b0;
    logic         tx_bit = 1'b0;
    logic         tx_flush = 1'b0;
    logic         tx_bit_ready;
    logic [W-1:0] enc_word;
    logic         enc_valid;
    logic         enc_ready = 1'b1;
    logic [W-1:0] dec_word = '0;
    logic         dec_valid = 1'b0;
    logic         dec_ready;
    logic         bit_strobe = 1'b0;
    logic         rx_bit;
    logic         rx_bit_valid;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    logic [W-1:0] encq[$];
    logic         rxq[$];

    ir_rle_codec #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rle_en(rle_en),
        .tx_bit_valid(tx_bit_valid), .tx_bit(tx_bit), .tx_flush(tx_flush),
        .tx_bit_ready(tx_bit_ready), .enc_word(enc_word), .enc_valid(enc_valid),
        .enc_ready(enc_ready), .dec_word(dec_word), .dec_valid(dec_valid),
        .dec_ready(dec_ready), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
        .rx_bit_valid(rx_bit_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    // Strobe every third cycle.
    always @(posedge clk) begin
        stb_cnt    <= (stb_cnt == 2) ? 0 : stb_cnt + 1;
        bit_strobe <= (stb_cnt == 1);
    end

    // Collect completed transfers on each edge (pre-edge values).
    always @(posedge clk) begin
        if (rst_n && enc_valid && enc_ready) encq.push_back(enc_word);
        if (rst_n && rx_bit_valid) rxq.push_back(rx_bit);
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        tx_bit_valid = 1'b1;
        tx_bit = b;
        while (!tx_bit_ready) @(negedge clk);
        @(negedge clk);
        tx_bit_valid = 1'b0;
    endtask

    task automatic send_run(input logic b, input int n);
        for (int i = 0; i < n; i++) send_bit(b);
    endtask

    task automatic do_flush();
        tx_flush = 1'b1;
        @(negedge clk);
        tx_flush = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input logic e);
        rle_en = e;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_word(input logic [W-1:0] w);
        dec_valid = 1'b1;
        dec_word = w;
        while (!dec_ready) @(negedge clk);
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic check_enc(input string req, input int n, input logic [W-1:0] w0,
                             input logic [W-1:0] w1);
        check(encq.size() == n, {req, " count"}, encq.size(), n);
        if (n > 0 && encq.size() > 0) check(encq[0] == w0, {req, " word0"}, encq[0], w0);
        if (n > 1 && encq.size() > 1) check(encq[1] == w1, {req, " word1"}, encq[1], w1);
        encq.delete();
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer", WD_CYC);
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(!enc_valid, "R1 enc_valid", enc_valid, 0);
        check(tx_bit_ready, "R1 tx_bit_ready", tx_bit_ready, 1);
        check(dec_ready, "R1 dec_ready", dec_ready, 1);
        check(!rx_bit_valid, "R1 rx_bit_valid", rx_bit_valid, 0);

        // R9 (and R1 bypass default): bits 1,0,1,1 pack LSB first -> 4'hD
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        repeat (2) @(negedge clk);
        check_enc("R9", 1, 4'hD, 4'h0);
        // R5: partial raw word 1,1 flushed -> 4'h3
        send_run(1'b1, 2);
        do_flush();
        check_enc("R5 raw partial", 1, 4'h3, 4'h0);
        // R5: nothing pending -> no word
        do_flush();
        check_enc("R5 empty", 0, 4'h0, 4'h0);

        set_mode(1'b1);
        // R2 R3: run 111 then 0 -> {1,2}=A, flush -> {0,0}=0
        send_run(1'b1, 3);
        send_bit(1'b0);
        @(negedge clk);
        check_enc("R3", 1, 4'hA, 4'h0);
        do_flush();
        check_enc("R2 flush", 1, 4'h0, 4'h0);
        // R4: eight zeros emit {0,7} without flush
        send_run(1'b0, 8);
        repeat (2) @(negedge clk);
        check_enc("R4 full", 1, 4'h7, 4'h0);
        do_flush();
        check_enc("R4 nothing left", 0, 4'h0, 4'h0);
        // R4: ten ones -> F then 9
        send_run(1'b1, 10);
        do_flush();
        check_enc("R4 split", 2, 4'hF, 4'h9);

        // R6: backpressure holds word and stalls input
        enc_ready = 1'b0;
        send_bit(1'b1);
        send_bit(1'b0);
        check(enc_valid && enc_word == 4'h8, "R6 word", enc_word, 4'h8);
        check(!tx_bit_ready, "R6 ready low", tx_bit_ready, 0);
        repeat (3) @(negedge clk);
        check(enc_valid && enc_word == 4'h8, "R6 held", enc_word, 4'h8);
        check(!tx_bit_ready, "R6 still stalled", tx_bit_ready, 0);
        enc_ready = 1'b1;
        @(negedge clk);
        do_flush();
        check_enc("R6 release", 2, 4'h8, 4'h0);

        // R11: mode change deferred while a run is pending
        send_run(1'b1, 2);
        set_mode(1'b0);
        send_bit(1'b1);
        do_flush();
        check_enc("R11 old mode kept", 1, 4'hA, 4'h0);
        repeat (2) @(negedge clk);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        repeat (2) @(negedge clk);
        check_enc("R11 new mode", 1, 4'h6, 4'h0);

        // R7 R10 R8: decoder vector table
        for (int i = 0; i < 6; i++) begin
            set_mode(DVEC[i].en);
            rxq.delete();
            send_word(DVEC[i].word);
            check(!dec_ready, "R8 busy after load", dec_ready, 0);
            while (!dec_ready) @(negedge clk);
            check(rxq.size() == int'(DVEC[i].len), DVEC[i].en ? "R7 length" : "R10 length",
                  rxq.size(), DVEC[i].len);
            for (int k = 0; k < rxq.size() && k < 8; k++) begin
                check(rxq[k] == DVEC[i].bits[k], DVEC[i].en ? "R7 bit" : "R10 bit",
                      rxq[k], DVEC[i].bits[k]);
            end
        end

        // R8: back-to-back words 9 (11) then 1 (00) replay in order
        set_mode(1'b1);
        rxq.delete();
        dec_valid = 1'b1;
        dec_word = 4'h9;
        @(negedge clk);
        dec_word = 4'h1;
        check(!dec_ready, "R8 second held", dec_ready, 0);
        while (!dec_ready) @(negedge clk);
        @(negedge clk);
        dec_valid = 1'b0;
        while (!dec_ready) @(negedge clk);
        check(rxq.size() == 4, "R8 total bits", rxq.size(), 4);
        if (rxq.size() == 4) begin
            check({rxq[0], rxq[1], rxq[2], rxq[3]} == 4'b1100, "R8 order",
                  {rxq[0], rxq[1], rxq[2], rxq[3]}, 4'b1100);
        end

        finish_sim();
    end

endmodule